// File: doc/BRIEF.md
# Synchronous burst SRAM with byte writes

This block is a clocked static RAM of 18-bit words with its own burst address generator, meant to serve as the data array of a cache. Every input except the output enable is captured in a register on the rising clock edge. The captured cycle is then decoded into one of three outcomes: a read, a write or an idle cycle.

A burst opens when either of two start inputs (one for a processor, one for a cache controller) is seen while the chip is selected. The captured address becomes the current address. After that, each cycle with the advance input set steps a 2-bit counter that forms the two low address bits. The counter wraps modulo 4, and the upper bits stay fixed. Writes need no external pulse. Any access cycle that has a half-word write enable set stores the captured data into the selected 9-bit halves when the next clock edge arrives.

Read data is held in an output register. The shared data port is split into an input, an output and a drive enable, which the pad ring combines into one tri-state bus. The drive enable follows the output-enable input asynchronously. The array depth is 2^ADDR_W words. ADDR_W is 16 for the full 65,536-word configuration, and the default is a smaller array.

Top module: `sbsram_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, dq_oe is 0. No burst is open after reset.
- R2: A cycle whose captured inputs have sel=1 and either start_cpu=1 or start_ctl=1 starts a burst at the captured address. If no write enable is set, the word at that address is on dq_o, with dq_oe=1 when oe=1, after the clock edge that follows the capturing edge.
- R3: A start input captured with sel=0 causes no access. It leaves dq_oe at 0 for that cycle's output slot and does not change the burst address.
- R4: An advance cycle (adv=1 captured, no start, burst open) sets the two low address bits to the previous value plus 1 modulo 4 and keeps the upper bits. For example, a burst started at 6 continues 7, 4, 5. Advance cycles do not depend on sel.
- R5: A cycle with neither a valid start nor a valid advance is idle: no access, no drive and the address is held. This includes adv=1 before any burst has been opened.
- R6: When a valid start and adv=1 are captured in the same cycle, the start wins and the access uses the captured address.
- R7: In an access cycle, wr_lo=1 writes bits 8:0 of dq_i and wr_hi=1 writes bits 17:9. The two may be set independently, and a half whose enable is 0 keeps its old contents.
- R8: dq_oe = oe AND (the previous registered cycle was a read access). It follows a change of oe without waiting for a clock edge. dq_oe is 0 in the output slot of a write cycle.
- R9: A read access of an address in the cycle right after a write to that address returns the newly written halves.
- R10: Advance cycles with write enables set write the successive burst addresses, so a burst of four writes fills a 4-word aligned block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except oe are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select; qualifies the start inputs |
| start_cpu | input | 1 | Processor-side burst start |
| start_ctl | input | 1 | Cache-controller-side burst start |
| adv | input | 1 | Burst advance; steps the 2-bit counter |
| wr_lo | input | 1 | Write enable for bits 8:0 |
| wr_hi | input | 1 | Write enable for bits 17:9 |
| oe | input | 1 | Asynchronous output enable |
| addr | input | ADDR_W | Word address captured at a start |
| dq_i | input | 18 | Write data from the shared bus |
| dq_o | output | 18 | Read data toward the shared bus |
| dq_oe | output | 1 | Drive enable of the shared bus |

## Verification
Two things can land in the same cycle. First, a start and an advance can be captured together, and the start must take the address while the counter step is dropped. Second, a write can be followed at once by a read of the same word, and the read must see the halves just written. The bench provokes both with directed cycles and through random streams confined to 32 addresses. It judges each read against a bench model of the burst state and memory, which is updated in cycle order. It also checks the drive enable twice per cycle: once at the output slot, and again 1 ns after oe changes.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int WORD_W  = 18;
    localparam int HALF_W  = WORD_W / 2;
    localparam int BURST_W = 2;

    typedef logic [WORD_W-1:0] word_t;

    // one captured bus cycle, controls only
    typedef struct packed {
        logic sel;
        logic start_cpu;
        logic start_ctl;
        logic adv;
        logic wr_lo;
        logic wr_hi;
    } ctl_t;

    // decoded operation handed to the array
    typedef struct packed {
        logic acc;
        logic wr_lo;
        logic wr_hi;
    } op_t;

    function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] cnt);
        return cnt + 1'b1;
    endfunction

    function automatic word_t merge_halves(input word_t old_w, input word_t new_w,
                                           input logic lo, input logic hi);
        word_t r;
        r[HALF_W-1:0]      = lo ? new_w[HALF_W-1:0]      : old_w[HALF_W-1:0];
        r[WORD_W-1:HALF_W] = hi ? new_w[WORD_W-1:HALF_W] : old_w[WORD_W-1:HALF_W];
        return r;
    endfunction

endpackage

// File: rtl/sbsram_in_reg.sv
module sbsram_in_reg
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  word_t             din_d,
    output ctl_t              ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output word_t             din_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        din_q  <= din_d;
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_q,
    input  logic [ADDR_W-1:0] addr_q,
    output op_t               op,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0]  cur_addr;
    logic               active;
    logic               start;
    logic               step;
    logic [BURST_W-1:0] lo_next;

    always_comb begin
        start   = ctl_q.sel & (ctl_q.start_cpu | ctl_q.start_ctl);
        step    = ~start & ctl_q.adv & active;
        lo_next = burst_next(cur_addr[BURST_W-1:0]);
        if (start)
            eff_addr = addr_q;
        else if (step)
            eff_addr = {cur_addr[ADDR_W-1:BURST_W], lo_next};
        else
            eff_addr = cur_addr;
        op.acc   = start | step;
        op.wr_lo = (start | step) & ctl_q.wr_lo;
        op.wr_hi = (start | step) & ctl_q.wr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cur_addr <= '0;
        end else begin
            if (start) active <= 1'b1;
            cur_addr <= eff_addr;
        end
    end

    // R4: advance wraps the low bits and keeps the upper bits
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> (cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + 2'd1) &&
                 (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

    // R5: idle cycles hold the burst address
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!start && !step) |=> $stable(cur_addr));

    // R6: a start loads the captured address even with advance set
    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> (cur_addr == $past(addr_q)) && active);

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  op_t               op,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             din,
    output word_t             rd_data,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];
    word_t old_word;
    logic  wr_any;

    always_comb begin
        old_word = mem[addr];
        wr_any   = op.wr_lo | op.wr_hi;
    end

    always_ff @(posedge clk) begin
        if (wr_any)
            mem[addr] <= merge_halves(old_word, din, op.wr_lo, op.wr_hi);
        if (op.acc && !wr_any)
            rd_data <= old_word;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= op.acc & ~wr_any;
    end

    // R7: a half whose enable is clear keeps its contents
    p_keep_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (op.wr_lo && !op.wr_hi) |=>
            mem[$past(addr)][WORD_W-1:HALF_W] == $past(old_word[WORD_W-1:HALF_W]));
    p_keep_lo_r7: assert property (@(posedge clk) disable iff (rst)
        (op.wr_hi && !op.wr_lo) |=>
            mem[$past(addr)][HALF_W-1:0] == $past(old_word[HALF_W-1:0]));

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel,
    input  logic                  start_cpu,
    input  logic                  start_ctl,
    input  logic                  adv,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  oe,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     dq_i,
    output logic [WORD_W-1:0]     dq_o,
    output logic                  dq_oe
);

    ctl_t              ctl_d, ctl_q;
    logic [ADDR_W-1:0] addr_q, eff_addr;
    word_t             din_q, rd_data;
    op_t               op;
    logic              rd_valid;

    assign ctl_d = '{sel: sel, start_cpu: start_cpu, start_ctl: start_ctl,
                     adv: adv, wr_lo: wr_lo, wr_hi: wr_hi};

    sbsram_in_reg #(.ADDR_W(ADDR_W)) u_in (
        .clk(clk), .rst(rst), .ctl_d(ctl_d), .addr_d(addr), .din_d(dq_i),
        .ctl_q(ctl_q), .addr_q(addr_q), .din_q(din_q)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst(rst), .ctl_q(ctl_q), .addr_q(addr_q),
        .op(op), .eff_addr(eff_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .op(op), .addr(eff_addr), .din(din_q),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign dq_o  = rd_data;
    assign dq_oe = oe & rd_valid;

    // R3: a cycle without access never drives the bus in its slot
    p_idle_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
        !op.acc |=> !dq_oe);

    // R8: a write cycle never drives the bus in its slot
    p_write_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (op.wr_lo || op.wr_hi) |=> !dq_oe);

endmodule

// File: tb/sbsram_top_tb.sv
module sbsram_top_tb;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 0, start_cpu = 0, start_ctl = 0, adv = 0;
    logic          wr_lo = 0, wr_hi = 0, oe = 1;
    logic [AW-1:0] addr = '0;
    logic [17:0]   dq_i = '0;
    logic [17:0]   dq_o;
    logic          dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sbsram_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .start_cpu(start_cpu), .start_ctl(start_ctl),
        .adv(adv), .wr_lo(wr_lo), .wr_hi(wr_hi), .oe(oe), .addr(addr),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // bench model
    logic [17:0]   mm [1 << AW];
    logic [AW-1:0] m_addr = '0;
    bit            m_active = 0;
    bit            w_prev = 0;
    logic [AW-1:0] w_prev_addr = '0;
    string         force_tag = "";

    // output-slot pipeline: o_* is two cycles old, n_* one cycle old
    bit          o_rd = 0, n_rd = 0;
    logic [17:0] o_val = '0, n_val = '0;
    string       o_tag = "R1", n_tag = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit ce_i, input bit sa, input bit sb, input bit ad,
                        input bit wl, input bit wh, input logic [AW-1:0] a,
                        input logic [17:0] d, input bit oe_i);
        bit start, stp, wr, rd;
        logic [AW-1:0] ea;
        string tg;
        @(negedge clk);
        chk(o_tag, {31'd0, dq_oe}, {31'd0, o_rd & oe});
        if (o_rd && oe) chk(o_tag, {14'd0, dq_o}, {14'd0, o_val});
        sel = ce_i; start_cpu = sa; start_ctl = sb; adv = ad;
        wr_lo = wl; wr_hi = wh; addr = a; dq_i = d; oe = oe_i;
        #1;
        chk("R8", {31'd0, dq_oe}, {31'd0, o_rd & oe_i});
        start = ce_i & (sa | sb);
        stp   = !start & ad & m_active;
        if (start)    ea = a;
        else if (stp) ea = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
        else          ea = m_addr;
        wr = (start | stp) & (wl | wh);
        rd = (start | stp) & !wr;
        if (force_tag != "")                      tg = force_tag;
        else if (rd && w_prev && ea == w_prev_addr) tg = "R9";
        else if (rd && start && ad)               tg = "R6";
        else if (rd && start)                     tg = "R2";
        else if (rd)                              tg = "R4";
        else if (wr)                              tg = "R8";
        else if ((sa || sb) && !ce_i)             tg = "R3";
        else                                      tg = "R5";
        o_rd = n_rd; o_val = n_val; o_tag = n_tag;
        n_rd = rd; n_val = mm[ea]; n_tag = tg;
        if (wr) begin
            if (wl) mm[ea][8:0]  = d[8:0];
            if (wh) mm[ea][17:9] = d[17:9];
        end
        w_prev = wr; w_prev_addr = ea;
        m_addr = ea;
        if (start) m_active = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, '0, '0, 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {31'd0, dq_oe}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R1", {31'd0, dq_oe}, 32'd0);

        // R5: advance before any burst is opened is ignored
        step(1, 0, 0, 1, 0, 0, 10'd3, '0, 1);
        step(1, 0, 0, 1, 0, 0, 10'd3, '0, 1);

        // R10: burst writes fill addresses 0..31, alternating start inputs
        force_tag = "R10";
        for (int b = 0; b < 8; b++) begin
            step(1, b[0], !b[0], 0, 1, 1, 10'(b * 4), 18'($urandom), 0);
            for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 1, 1, '0, 18'($urandom), 0);
        end
        // R10: read block 0 back in burst order
        step(1, 1, 0, 0, 0, 0, 10'd0, '0, 1);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0, '0, '0, 1);
        force_tag = "";

        // R2/R4: burst from 6 wraps 7, 4, 5
        step(1, 0, 1, 0, 0, 0, 10'd6, '0, 1);
        for (int k = 0; k < 3; k++) step(1, 0, 0, 1, 0, 0, '0, '0, 1);
        // R3: start without select is ignored, then advance continues old burst
        step(0, 1, 1, 0, 0, 0, 10'd20, '0, 1);
        step(0, 0, 0, 1, 0, 0, '0, '0, 1);
        // R6: start with advance set loads the captured address
        step(1, 1, 0, 1, 0, 0, 10'd13, '0, 1);
        step(1, 0, 0, 1, 0, 0, '0, '0, 1);

        // R7 and R9: half writes, each read back at once and after a gap
        step(1, 1, 0, 0, 1, 0, 10'd5, 18'h2a5a5, 0);
        step(1, 1, 0, 0, 0, 0, 10'd5, '0, 1);
        step(1, 0, 1, 0, 0, 1, 10'd9, 18'h15a5a, 0);
        step(1, 0, 1, 0, 0, 0, 10'd9, '0, 1);
        idle(1);
        force_tag = "R7";
        step(1, 1, 0, 0, 0, 0, 10'd5, '0, 1);
        step(1, 1, 0, 0, 0, 0, 10'd9, '0, 1);
        force_tag = "";

        // random mix over a 32-word window
        for (int i = 0; i < 600; i++) begin
            bit ce_r, sa_r, sb_r, ad_r, wl_r, wh_r, oe_r;
            ce_r = ($urandom % 10) < 8;
            sa_r = ($urandom % 10) < 2;
            sb_r = ($urandom % 10) < 2;
            ad_r = ($urandom % 2) == 1;
            wl_r = ($urandom % 10) < 2;
            wh_r = ($urandom % 10) < 2;
            oe_r = ($urandom % 10) < 8;
            step(ce_r, sa_r, sb_r, ad_r, wl_r, wh_r, 10'($urandom % 32),
                 18'($urandom), oe_r);
        end
        idle(3);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule